// File: doc/BRIEF.md
# Clock Mode Strap Capture and Loss-of-Clock Status

This block fixes the system clock mode of a chip from three strap pins and keeps a sticky record of clock failures. While the system reset is held, it samples the straps on every clock edge and decodes them into one of four clock modes. Once reset is released, it holds that mode and ignores the pins. If the straps move while reset is held, a loss-of-lock indication is raised in that same cycle. This indication is meant for the PLL control logic outside the block.

The status flag records a loss-of-clock pulse from an external detector. The pulse is accepted when the enable input is set. It is also accepted while the oscillator is still recovering after a fast-wakeup stop in which the PLL and oscillator were switched off. During that recovery the flag also reads 1 on its own. In external clock mode the flag always reads 0.

Software reads the flag through a valid/ready read port with one cycle of latency. A request is taken when `rd_valid_i` and `rd_ready_o` are both high. The response stays valid and unchanged until `rdata_ready_i` is high. While an untaken response is pending, `rd_ready_o` stays low. This applies back-pressure to the requester.

Top module: `clkmode_locs_ctrl`

## Requirements
- R1: While `rst_n` is low, the straps are sampled at each clock edge, and `mode_o` shows the decoded mode after that edge. The strap bits are {bit2 PLL enable, bit1 PLL select, bit0 reference}. The codes map as follows: 000 gives mode 0 (external clock), 100 gives mode 1 (1:1 PLL), 110 gives mode 2 (PLL with external reference), and 111 gives mode 3 (PLL with crystal).
- R2: While `rst_n` is high, strap changes have no effect on `mode_o` or on `lol_o`.
- R3: Any other strap code decodes to mode 0 and sets `strap_err_o` to 1. The four valid codes leave `strap_err_o` at 0.
- R4: `lol_o` is high in any cycle in which `rst_n` is low and the straps differ from the value captured at the previous edge. This holds only after the first capture since power-on reset. Otherwise `lol_o` is 0.
- R5: Power-on reset (`por_n` low) sets `mode_o` to 0, `strap_err_o` to 0, and the flag to 0, and leaves no response pending. A plain `rst_n` reset clears the flag.
- R6: In any PLL mode, a loss-of-clock pulse with the enable set makes the flag 1. The flag stays 1 until the next reset.
- R7: A loss-of-clock pulse with the enable clear, outside oscillator recovery, does not change the flag.
- R8: In mode 0 the flag reads 0, whatever pulses or stops occur.
- R9: Suppose stop mode (`stop_i` high) is entered with `fwkup_i` set and `stop_code_i` equal to 2'b11. The flag then reads 1 from the cycle after `stop_i` is sampled low until the edge that samples `osc_ready_i` high. After that it reads its sticky value. Stops with any other code, or with `fwkup_i` clear, do not affect the flag.
- R10: During that recovery, a loss-of-clock pulse is recorded even with the enable clear, and the flag stays 1 after recovery ends.
- R11: A read taken at an edge returns, after that edge, `rdata_valid_o` high and `rdata_o` with the flag in bit 2 and all other bits 0. The flag value is the one from before any update made at the same edge.
- R12: While `rdata_valid_o` is high and `rdata_ready_i` is low, `rdata_o` holds steady and `rd_ready_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_n | input | 1 | System reset level, active low; straps are sampled while low |
| strap_i | input | 3 | Clock mode straps {PLL enable, PLL select, reference} |
| loc_pulse_i | input | 1 | Loss-of-clock detector pulse |
| loc_en_i | input | 1 | Loss-of-clock recording enable |
| stop_i | input | 1 | High while the chip is in stop mode |
| stop_code_i | input | 2 | Stop-mode clock control; 2'b11 means PLL and oscillator off |
| fwkup_i | input | 1 | Fast wakeup selected |
| osc_ready_i | input | 1 | Oscillator has restarted |
| mode_o | output | 2 | Decoded clock mode |
| strap_err_o | output | 1 | Straps held an undecoded code |
| lol_o | output | 1 | Loss-of-lock from a strap change in reset |
| rd_valid_i | input | 1 | Status read request |
| rd_ready_o | output | 1 | Read request can be taken |
| rdata_valid_o | output | 1 | Read response valid |
| rdata_o | output | 8 | Status word, flag in bit 2 |
| rdata_ready_i | input | 1 | Requester takes the response |

## Verification
The assertions assume two things about the inputs. The straps are driven to known values before power-on reset is released. And `rst_n` stays low for at least one edge after `por_n` rises, so the first capture takes place. The stop checks assume `stop_i` is a level that holds for whole cycles, and that `osc_ready_i` is low when the stop ends. The bench changes every input only at falling clock edges and keeps the oscillator-ready input low through each stop exit. It applies power-on reset once, with both resets low and the straps set.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;

  typedef enum logic [1:0] {
    MODE_EXT        = 2'd0,
    MODE_PLL_1TO1   = 2'd1,
    MODE_PLL_EXTREF = 2'd2,
    MODE_PLL_XTAL   = 2'd3
  } clk_mode_e;

  localparam int STRAP_W = 3;
  localparam int STOP_W  = 2;
  localparam logic [STOP_W-1:0] STOP_ALL_OFF = 2'b11;

  // Straps: {pll enable, pll select, reference}
  function automatic clk_mode_e strap_decode(input logic [STRAP_W-1:0] s);
    case (s)
      3'b100:  return MODE_PLL_1TO1;
      3'b110:  return MODE_PLL_EXTREF;
      3'b111:  return MODE_PLL_XTAL;
      default: return MODE_EXT;
    endcase
  endfunction

  function automatic logic strap_valid(input logic [STRAP_W-1:0] s);
    return (s == 3'b000) || (s == 3'b100) || (s == 3'b110) || (s == 3'b111);
  endfunction

endpackage

// File: rtl/clkmode_strap_latch.sv
module clkmode_strap_latch
  import clkmode_pkg::*;
(
  input  logic               clk,
  input  logic               por_n,
  input  logic               rst_n,
  input  logic [STRAP_W-1:0] strap_i,
  output clk_mode_e          mode_o,
  output logic               strap_err_o,
  output logic               lol_o
);

  logic [STRAP_W-1:0] strap_q;
  logic               have_q;
  clk_mode_e          mode_q;
  logic               err_q;
  clk_mode_e          mode_d;
  logic               err_d;

  always_comb begin
    mode_d = strap_decode(strap_i);
    err_d  = !strap_valid(strap_i);
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      strap_q <= '0;
      have_q  <= 1'b0;
      mode_q  <= MODE_EXT;
      err_q   <= 1'b0;
    end else if (!rst_n) begin
      strap_q <= strap_i;
      have_q  <= 1'b1;
      mode_q  <= mode_d;
      err_q   <= err_d;
    end
  end

  assign lol_o       = !rst_n && have_q && (strap_i != strap_q);
  assign mode_o      = mode_q;
  assign strap_err_o = err_q;

  assert_mode_frozen_R2: assert property (@(posedge clk) disable iff (!por_n)
    (rst_n && $past(rst_n)) |-> $stable(mode_q));

  assert_lol_quiet_R4: assert property (@(posedge clk) disable iff (!por_n)
    (!rst_n && !$past(rst_n) && $stable(strap_i)) |-> !lol_o);

endmodule

// File: rtl/clkmode_loc_status.sv
module clkmode_loc_status
  import clkmode_pkg::*;
(
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  clk_mode_e         mode_i,
  input  logic              loc_pulse_i,
  input  logic              loc_en_i,
  input  logic              stop_i,
  input  logic [STOP_W-1:0] stop_code_i,
  input  logic              fwkup_i,
  input  logic              osc_ready_i,
  output logic              flag_o
);

  logic ext_mode;
  logic sticky_q, armed_q, recovering_q;
  logic arm_now, recover_start, record_loc;

  assign ext_mode      = (mode_i == MODE_EXT);
  assign arm_now       = stop_i && fwkup_i && (stop_code_i == STOP_ALL_OFF) && !ext_mode;
  assign recover_start = armed_q && !stop_i;
  assign record_loc    = loc_pulse_i && (loc_en_i || recovering_q) && !ext_mode;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      sticky_q     <= 1'b0;
      armed_q      <= 1'b0;
      recovering_q <= 1'b0;
    end else if (!rst_n) begin
      sticky_q     <= 1'b0;
      armed_q      <= 1'b0;
      recovering_q <= 1'b0;
    end else begin
      if (record_loc) sticky_q <= 1'b1;
      if (recover_start)  armed_q <= 1'b0;
      else if (arm_now)   armed_q <= 1'b1;
      if (recovering_q)   recovering_q <= !osc_ready_i;
      else                recovering_q <= recover_start;
    end
  end

  assign flag_o = !ext_mode && (sticky_q || recovering_q);

  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    sticky_q |=> sticky_q);

  assert_disabled_ignored_R7: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (loc_pulse_i && !loc_en_i && !recovering_q && !sticky_q) |=> !sticky_q);

  assert_ext_no_record_R8: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    ext_mode |=> !sticky_q);

  assert_recover_after_stop_R9: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    $rose(recovering_q) |-> ($past(armed_q) && !$past(stop_i)));

endmodule

// File: rtl/clkmode_rdport.sv
module clkmode_rdport #(
  parameter int DATA_W   = 8,
  parameter int FLAG_BIT = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              flag_i,
  input  logic              rd_valid_i,
  output logic              rd_ready_o,
  output logic              rdata_valid_o,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              rdata_ready_i
);

  logic [DATA_W-1:0] word;
  logic              resp_q;
  logic [DATA_W-1:0] data_q;
  logic              take;

  for (genvar b = 0; b < DATA_W; b++) begin : g_word
    if (b == FLAG_BIT) begin : g_flag
      assign word[b] = flag_i;
    end else begin : g_zero
      assign word[b] = 1'b0;
    end
  end

  assign rd_ready_o = !resp_q || rdata_ready_i;
  assign take       = rd_valid_i && rd_ready_o;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      resp_q <= 1'b0;
      data_q <= '0;
    end else if (!rst_n) begin
      resp_q <= 1'b0;
      data_q <= '0;
    end else if (take) begin
      resp_q <= 1'b1;
      data_q <= word;
    end else if (rdata_ready_i) begin
      resp_q <= 1'b0;
    end
  end

  assign rdata_valid_o = resp_q;
  assign rdata_o       = data_q;

  assert_resp_follows_R11: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (rd_valid_i && rd_ready_o) |=> rdata_valid_o);

  assert_resp_hold_R12: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (rdata_valid_o && !rdata_ready_i) |=> (rdata_valid_o && $stable(rdata_o)));

endmodule

// File: rtl/clkmode_locs_ctrl.sv
module clkmode_locs_ctrl
  import clkmode_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int FLAG_BIT = 2
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               rst_n,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               loc_pulse_i,
  input  logic               loc_en_i,
  input  logic               stop_i,
  input  logic [STOP_W-1:0]  stop_code_i,
  input  logic               fwkup_i,
  input  logic               osc_ready_i,
  output logic [1:0]         mode_o,
  output logic               strap_err_o,
  output logic               lol_o,
  input  logic               rd_valid_i,
  output logic               rd_ready_o,
  output logic               rdata_valid_o,
  output logic [DATA_W-1:0]  rdata_o,
  input  logic               rdata_ready_i
);

  clk_mode_e mode;
  logic      flag;

  clkmode_strap_latch u_latch (
    .clk         (clk),
    .por_n       (por_n),
    .rst_n       (rst_n),
    .strap_i     (strap_i),
    .mode_o      (mode),
    .strap_err_o (strap_err_o),
    .lol_o       (lol_o)
  );

  clkmode_loc_status u_status (
    .clk         (clk),
    .por_n       (por_n),
    .rst_n       (rst_n),
    .mode_i      (mode),
    .loc_pulse_i (loc_pulse_i),
    .loc_en_i    (loc_en_i),
    .stop_i      (stop_i),
    .stop_code_i (stop_code_i),
    .fwkup_i     (fwkup_i),
    .osc_ready_i (osc_ready_i),
    .flag_o      (flag)
  );

  clkmode_rdport #(.DATA_W(DATA_W), .FLAG_BIT(FLAG_BIT)) u_rd (
    .clk           (clk),
    .por_n         (por_n),
    .rst_n         (rst_n),
    .flag_i        (flag),
    .rd_valid_i    (rd_valid_i),
    .rd_ready_o    (rd_ready_o),
    .rdata_valid_o (rdata_valid_o),
    .rdata_o       (rdata_o),
    .rdata_ready_i (rdata_ready_i)
  );

  assign mode_o = mode;

  assert_err_means_ext_R3: assert property (@(posedge clk) disable iff (!por_n)
    strap_err_o |-> (mode_o == MODE_EXT));

  assert_ext_reads_zero_R8: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (rd_valid_i && rd_ready_o && mode_o == MODE_EXT) |=> (rdata_o[FLAG_BIT] == 1'b0));

endmodule

// File: tb/test_clkmode_locs_ctrl.sv
`timescale 1ns/1ps
module test_clkmode_locs_ctrl;

  logic       clk = 1'b0;
  logic       por_n, rst_n;
  logic [2:0] strap;
  logic       loc_pulse, loc_en, stop, fwkup, osc_ready;
  logic [1:0] stop_code;
  logic       rd_valid, rdata_ready;
  logic [1:0] mode;
  logic       strap_err, lol, rd_ready, rdata_valid;
  logic [7:0] rdata;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  clkmode_locs_ctrl i_clkmode_locs_ctrl (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .strap_i(strap),
    .loc_pulse_i(loc_pulse), .loc_en_i(loc_en), .stop_i(stop),
    .stop_code_i(stop_code), .fwkup_i(fwkup), .osc_ready_i(osc_ready),
    .mode_o(mode), .strap_err_o(strap_err), .lol_o(lol),
    .rd_valid_i(rd_valid), .rd_ready_o(rd_ready), .rdata_valid_o(rdata_valid),
    .rdata_o(rdata), .rdata_ready_i(rdata_ready)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_mode(input logic [2:0] s);
    case (s)
      3'b100: return 1;
      3'b110: return 2;
      3'b111: return 3;
      default: return 0;
    endcase
  endfunction

  // one read with rdata_ready high; returns data, or -1 if no response
  task automatic do_read(output int v);
    @(negedge clk) rd_valid = 1'b1;
    @(negedge clk) rd_valid = 1'b0;
    v = rdata_valid ? int'(rdata) : -1;
  endtask

  task automatic pulse_loc(input logic en);
    @(negedge clk) begin loc_pulse = 1'b1; loc_en = en; end
    @(negedge clk) begin loc_pulse = 1'b0; loc_en = 1'b0; end
  endtask

  task automatic warm_reset(input logic [2:0] s);
    @(negedge clk) begin rst_n = 1'b0; strap = s; end
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic stop_cycle(input logic fw, input logic [1:0] code);
    @(negedge clk) begin osc_ready = 1'b0; fwkup = fw; stop_code = code; stop = 1'b1; end
    @(negedge clk) stop = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_power_on;
    por_n = 1'b0; rst_n = 1'b0; strap = 3'b110;
    repeat (2) @(negedge clk);
    chk(mode == 2'd0, "R5 mode in POR", mode, 0);
    chk(strap_err == 1'b0, "R5 err in POR", strap_err, 0);
    chk(rdata_valid == 1'b0, "R5 no response in POR", rdata_valid, 0);
    por_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(mode == 2'd2, "R1 mode 110", mode, 2);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_decode;
    logic [2:0] prev;
    prev = strap;
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    for (int c = 0; c < 8; c++) begin
      strap = 3'(c);
      #1;
      chk(lol == (3'(c) != prev), "R4 lol on strap change", lol, (3'(c) != prev));
      @(negedge clk);
      chk(int'(mode) == exp_mode(3'(c)), "R1 R3 decoded mode", mode, exp_mode(3'(c)));
      chk(strap_err == (exp_mode(3'(c)) == 0 && c != 0), "R3 strap error", strap_err,
          (exp_mode(3'(c)) == 0 && c != 0));
      chk(lol == 1'b0, "R4 lol after capture", lol, 0);
      prev = 3'(c);
    end
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk) strap = 3'b000;
    #1;
    chk(lol == 1'b0, "R2 no lol out of reset", lol, 0);
    @(negedge clk);
    chk(mode == 2'd3, "R2 mode frozen", mode, 3);
  endtask

  task automatic t_sticky;
    int v;
    warm_reset(3'b111);
    do_read(v); chk(v == 0, "R5 flag clear after reset", v, 0);
    pulse_loc(1'b1);
    do_read(v); chk(v == 4, "R6 flag set", v, 4);
    repeat (5) @(negedge clk);
    do_read(v); chk(v == 4, "R6 flag stays", v, 4);
    warm_reset(3'b111);
    do_read(v); chk(v == 0, "R5 rst_n clears flag", v, 0);
    pulse_loc(1'b0);
    do_read(v); chk(v == 0, "R7 disabled pulse ignored", v, 0);
  endtask

  task automatic t_same_cycle;
    int v;
    warm_reset(3'b100);
    @(negedge clk) begin rd_valid = 1'b1; loc_pulse = 1'b1; loc_en = 1'b1; end
    @(negedge clk) begin rd_valid = 1'b0; loc_pulse = 1'b0; loc_en = 1'b0; end
    v = rdata_valid ? int'(rdata) : -1;
    chk(v == 0, "R11 read gets value before update", v, 0);
    do_read(v); chk(v == 4, "R11 later read sees event", v, 4);
  endtask

  task automatic t_ext;
    int v;
    warm_reset(3'b000);
    pulse_loc(1'b1);
    do_read(v); chk(v == 0, "R8 ext mode pulse", v, 0);
    stop_cycle(1'b1, 2'b11);
    do_read(v); chk(v == 0, "R8 ext mode stop exit", v, 0);
  endtask

  task automatic t_stop;
    int v;
    warm_reset(3'b111);
    stop_cycle(1'b1, 2'b10);
    do_read(v); chk(v == 0, "R9 other stop code", v, 0);
    stop_cycle(1'b0, 2'b11);
    do_read(v); chk(v == 0, "R9 no fast wakeup", v, 0);
    stop_cycle(1'b1, 2'b11);
    do_read(v); chk(v == 4, "R9 flag during recovery", v, 4);
    @(negedge clk) osc_ready = 1'b1;
    do_read(v); chk(v == 0, "R9 flag clears on osc ready", v, 0);
    stop_cycle(1'b1, 2'b11);
    pulse_loc(1'b0);
    @(negedge clk) osc_ready = 1'b1;
    do_read(v); chk(v == 4, "R10 pulse recorded in recovery", v, 4);
  endtask

  task automatic t_backpressure;
    logic [7:0] held;
    warm_reset(3'b110);
    @(negedge clk) begin rdata_ready = 1'b0; rd_valid = 1'b1; end
    @(negedge clk) rd_valid = 1'b0;
    chk(rdata_valid == 1'b1, "R11 response valid", rdata_valid, 1);
    chk(rdata == 8'd0, "R11 data", rdata, 0);
    chk(rd_ready == 1'b0, "R12 not ready while stalled", rd_ready, 0);
    held = rdata;
    pulse_loc(1'b1);
    @(negedge clk);
    chk(rdata_valid == 1'b1 && rdata == held, "R12 data held", rdata, held);
    rdata_ready = 1'b1;
    #1;
    chk(rd_ready == 1'b1, "R12 ready when taken", rd_ready, 1);
    @(negedge clk);
    chk(rdata_valid == 1'b0, "R12 response retired", rdata_valid, 0);
  endtask

  initial begin
    loc_pulse = 0; loc_en = 0; stop = 0; fwkup = 0; osc_ready = 0;
    stop_code = 2'b00; rd_valid = 0; rdata_ready = 1;
    t_power_on();
    t_decode();
    t_sticky();
    t_same_cycle();
    t_ext();
    t_stop();
    t_backpressure();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule